// File: doc/BRIEF.md
# Iterative IDEA Block Encryptor with Word-Wide Memory Commands

This block encrypts one 64-bit block with the IDEA cipher at a time. It has no wide key or data ports. A start pulse hands it three word addresses: the subkey table, the plaintext and the ciphertext destination. The engine then issues 32-bit LOAD commands to fetch the plaintext and the 52 precomputed 16-bit subkeys. It runs the eight rounds and the output transformation on a single shared modular multiplier. It then issues two 32-bit STORE commands for the ciphertext. Addresses count in 32-bit words, so consecutive words differ by one.

Key expansion from the 128-bit user key happens elsewhere: the subkey table must already be in memory. Each memory command holds until the memory acknowledges it, so the engine stalls through any memory latency. The block finishes one encryption completely before it accepts another.

Top module: `idea_seq_core`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are all 0.
- R2: A `start` seen while idle latches `key_base`, `src_base` and `dst_base`. A `start` while `busy` is 1 has no effect: the running block keeps its original addresses, and no second run follows.
- R3: Each block makes exactly 28 reads, in this order: `src_base`, `src_base+1`, then `key_base+0` through `key_base+25`. The plaintext word at `src_base` holds plaintext word 1 in bits 31:16 and word 2 in bits 15:0, and `src_base+1` holds words 3 and 4. The key word at `key_base+j` holds subkey 2j+1 in bits 31:16 and subkey 2j+2 in bits 15:0, with subkeys numbered from 1.
- R4: While `mem_req` is 1 and `mem_ack` is 0, the command stays unchanged on the next cycle: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` are all held. A command completes in the cycle in which `mem_ack` is 1, whatever the latency.
- R5: The ciphertext equals IDEA encryption of the plaintext. Multiplication is modulo 65537, with the 16-bit value 0 standing for 65536, and addition is modulo 65536. There are 8 rounds using subkeys 1 to 48. The output transformation uses subkeys 49 to 52 and leaves the two middle words unswapped.
- R6: Each block makes exactly 2 writes, after all reads: `{Y1,Y2}` to `dst_base` and then `{Y3,Y4}` to `dst_base+1`.
- R7: `done` is 1 for exactly one cycle, the cycle after the acknowledge of the second store, and `busy` is already 0 in that cycle.
- R8: While `busy` is 0, `mem_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one block encryption when idle |
| key_base | input | ADDR_W | Word address of the subkey table |
| src_base | input | ADDR_W | Word address of the plaintext |
| dst_base | input | ADDR_W | Word address for the ciphertext |
| busy | output | 1 | Engine is working on a block |
| done | output | 1 | One-cycle pulse when the ciphertext is stored |
| mem_req | output | 1 | Memory command valid |
| mem_we | output | 1 | 1 = STORE, 0 = LOAD |
| mem_addr | output | ADDR_W | Word address of the command |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory has completed the current command |
| mem_rdata | input | 32 | Load data, valid while `mem_ack` is 1 |

## Verification
The assertions assume that the memory raises `mem_ack` only while a command is pending and presents load data in that same cycle. They also assume that it eventually acknowledges every command. The bench memory model keeps to this: it acknowledges a pending request after a chosen number of wait cycles, from zero to three, and then drops the acknowledge for one cycle. Random subkey tables and plaintexts are mixed with a published test vector, with all-zero subkeys, and with subkey values of 1 and 0xFFFF. A second start is driven while a block is in flight and must have no effect.

// File: rtl/idea_pkg.sv
package idea_pkg;
   typedef logic [15:0] half_t;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_LOAD  = 2'd1,
      ENG_CALC  = 2'd2,
      ENG_STORE = 2'd3
   } eng_state_t;

   // subkeys per cipher: six per round plus four for the output step
   function automatic int unsigned subkey_total(input int unsigned rounds);
      return 6 * rounds + 4;
   endfunction
endpackage

// File: rtl/idea_mulmod.sv
module idea_mulmod #(
   parameter int IMPL = 0
) (
   input  logic [15:0] a,
   input  logic [15:0] b,
   output logic [15:0] p
);
   generate
      if (IMPL == 0) begin : g_lowhigh
         logic [31:0] prod;
         logic [15:0] lo, hi;
         always_comb begin
            prod = {16'd0, a} * {16'd0, b};
            lo   = prod[15:0];
            hi   = prod[31:16];
            if (a == 16'd0)
               p = 16'd1 - b;
            else if (b == 16'd0)
               p = 16'd1 - a;
            else
               p = lo - hi + {15'd0, (lo < hi)};
         end
      end else if (IMPL == 1) begin : g_modulo
         logic [16:0] ax, bx;
         logic [33:0] prod;
         always_comb begin
            ax   = (a == 16'd0) ? 17'h10000 : {1'b0, a};
            bx   = (b == 16'd0) ? 17'h10000 : {1'b0, b};
            prod = {17'd0, ax} * {17'd0, bx};
            p    = 16'(prod % 34'd65537);
         end
      end else begin : g_bad_impl
         $error("idea_mulmod: IMPL must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/idea_key_bank.sv
module idea_key_bank #(
   parameter int NUM_SUB = 52,
   parameter int PAIR_W  = 5,
   parameter int IDX_W   = 6
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PAIR_W-1:0] wr_pair,
   input  logic [31:0]       wr_word,
   input  logic [IDX_W-1:0]  rd_base,
   output logic [5:0][15:0]  sk
);
   localparam int DEPTH = 1 << IDX_W;

   if (NUM_SUB + 6 > DEPTH) begin : g_bad_depth
      $error("idea_key_bank: index width too small");
   end
   if (IDX_W != PAIR_W + 1) begin : g_bad_width
      $error("idea_key_bank: IDX_W must be PAIR_W+1");
   end

   logic [15:0] bank [DEPTH];
   logic [IDX_W-1:0] wa_hi, wa_lo;

   assign wa_hi = {wr_pair, 1'b0};
   assign wa_lo = {wr_pair, 1'b1};

   always_ff @(posedge clk) begin
      if (wr_en) begin
         bank[wa_hi] <= wr_word[31:16];
         bank[wa_lo] <= wr_word[15:0];
      end
   end

   for (genvar g = 0; g < 6; g++) begin : g_rd
      logic [IDX_W-1:0] ridx;
      assign ridx  = rd_base + IDX_W'(g);
      assign sk[g] = (32'(ridx) < NUM_SUB) ? bank[ridx] : 16'd0;
   end
endmodule

// File: rtl/idea_round_dp.sv
module idea_round_dp #(
   parameter int MUL_IMPL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic             ld_sel,
   input  logic [31:0]      ld_word,
   input  logic             step_en,
   input  logic [1:0]       phase,
   input  logic             final_rnd,
   input  logic [5:0][15:0] sk,
   output logic [31:0]      ct_hi,
   output logic [31:0]      ct_lo
);
   logic [15:0] x1, x2, x3, x4;
   logic [15:0] t1, t2, t3, t4, m1;
   logic [15:0] mul_a, mul_b, mul_p, bsum;

   always_comb begin
      unique case (phase)
         2'd0: begin mul_a = x1;               mul_b = sk[0]; end
         2'd1: begin mul_a = x4;               mul_b = sk[3]; end
         2'd2: begin mul_a = t1 ^ t3;          mul_b = sk[4]; end
         default: begin mul_a = (t2 ^ t4) + m1; mul_b = sk[5]; end
      endcase
   end

   idea_mulmod #(.IMPL(MUL_IMPL)) u_mul (.a(mul_a), .b(mul_b), .p(mul_p));

   assign bsum = m1 + mul_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x1 <= '0; x2 <= '0; x3 <= '0; x4 <= '0;
         t1 <= '0; t2 <= '0; t3 <= '0; t4 <= '0; m1 <= '0;
      end else if (ld_en) begin
         if (ld_sel) {x3, x4} <= ld_word;
         else        {x1, x2} <= ld_word;
      end else if (step_en) begin
         unique case (phase)
            2'd0: begin
               t1 <= mul_p;
               t2 <= (final_rnd ? x3 : x2) + sk[1];
               t3 <= (final_rnd ? x2 : x3) + sk[2];
            end
            2'd1: t4 <= mul_p;
            2'd2: m1 <= mul_p;
            default: begin
               x1 <= t1 ^ mul_p;
               x2 <= t3 ^ mul_p;
               x3 <= t2 ^ bsum;
               x4 <= t4 ^ bsum;
            end
         endcase
      end
   end

   assign ct_hi = {t1, t2};
   assign ct_lo = {t3, t4};

   AST_MUL_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_b == 16'd1) |-> (mul_p == mul_a)); // R5
   AST_MUL_MAX_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_a == 16'd0 && mul_b == 16'd0) |-> (mul_p == 16'd1)); // R5
endmodule

// File: rtl/idea_seq_core.sv
module idea_seq_core
   import idea_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int NUM_ROUNDS = 8,
   parameter int MUL_IMPL   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] key_base,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   output logic              busy,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);
   localparam int NUM_SUB    = int'(subkey_total(NUM_ROUNDS));
   localparam int KEY_WORDS  = NUM_SUB / 2;
   localparam int LOAD_WORDS = KEY_WORDS + 2;
   localparam int CNT_W      = $clog2(LOAD_WORDS + 1);
   localparam int PAIR_W     = $clog2(KEY_WORDS);
   localparam int IDX_W      = PAIR_W + 1;
   localparam int RND_W      = $clog2(NUM_ROUNDS + 1);

   if (NUM_ROUNDS < 1) begin : g_bad_rounds
      $error("idea_seq_core: NUM_ROUNDS must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("idea_seq_core: ADDR_W too small");
   end

   eng_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [RND_W-1:0]  rnd_q;
   logic [1:0]        ph_q;
   logic              done_q;
   logic [ADDR_W-1:0] key_q, src_q, dst_q;

   logic              final_rnd, in_data, ld_en, key_wr, step_en;
   logic [CNT_W-1:0]  key_off;
   logic [IDX_W-1:0]  rd_base;
   logic [5:0][15:0]  sk;
   logic [31:0]       ct_hi, ct_lo;

   assign final_rnd = (rnd_q == RND_W'(NUM_ROUNDS));
   assign in_data   = (cnt_q < CNT_W'(2));
   assign key_off   = cnt_q - CNT_W'(2);
   assign ld_en     = (state_q == ENG_LOAD) && mem_ack && in_data;
   assign key_wr    = (state_q == ENG_LOAD) && mem_ack && !in_data;
   assign step_en   = (state_q == ENG_CALC);
   assign rd_base   = IDX_W'(32'(rnd_q) * 32'd6);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         cnt_q   <= '0;
         rnd_q   <= '0;
         ph_q    <= '0;
         done_q  <= 1'b0;
         key_q   <= '0;
         src_q   <= '0;
         dst_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ENG_IDLE: begin
               if (start) begin
                  key_q   <= key_base;
                  src_q   <= src_base;
                  dst_q   <= dst_base;
                  cnt_q   <= '0;
                  state_q <= ENG_LOAD;
               end
            end
            ENG_LOAD: begin
               if (mem_ack) begin
                  if (cnt_q == CNT_W'(LOAD_WORDS - 1)) begin
                     cnt_q   <= '0;
                     rnd_q   <= '0;
                     ph_q    <= '0;
                     state_q <= ENG_CALC;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            ENG_CALC: begin
               ph_q <= ph_q + 2'd1;
               if (final_rnd) begin
                  if (ph_q == 2'd1) begin
                     ph_q    <= '0;
                     state_q <= ENG_STORE;
                  end
               end else if (ph_q == 2'd3) begin
                  rnd_q <= rnd_q + RND_W'(1);
               end
            end
            default: begin
               if (mem_ack) begin
                  if (cnt_q == CNT_W'(1)) begin
                     cnt_q   <= '0;
                     done_q  <= 1'b1;
                     state_q <= ENG_IDLE;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
         endcase
      end
   end

   always_comb begin
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state_q)
         ENG_LOAD:  mem_addr = in_data ? src_q + ADDR_W'(cnt_q) : key_q + ADDR_W'(key_off);
         ENG_STORE: begin
            mem_addr  = dst_q + ADDR_W'(cnt_q);
            mem_wdata = cnt_q[0] ? ct_lo : ct_hi;
         end
         default: ;
      endcase
   end

   assign mem_req = (state_q == ENG_LOAD) || (state_q == ENG_STORE);
   assign mem_we  = (state_q == ENG_STORE);
   assign busy    = (state_q != ENG_IDLE);
   assign done    = done_q;

   idea_key_bank #(.NUM_SUB(NUM_SUB), .PAIR_W(PAIR_W), .IDX_W(IDX_W)) u_keys (
      .clk     (clk),
      .wr_en   (key_wr),
      .wr_pair (PAIR_W'(key_off)),
      .wr_word (mem_rdata),
      .rd_base (rd_base),
      .sk      (sk)
   );

   idea_round_dp #(.MUL_IMPL(MUL_IMPL)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (ld_en),
      .ld_sel    (cnt_q[0]),
      .ld_word   (mem_rdata),
      .step_en   (step_en),
      .phase     (ph_q),
      .final_rnd (final_rnd),
      .sk        (sk),
      .ct_hi     (ct_hi),
      .ct_lo     (ct_lo)
   );

   // per-block transfer tallies used only by the checks below
   logic [CNT_W-1:0] rd_seen_q, wr_seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_seen_q <= '0;
         wr_seen_q <= '0;
      end else if (!busy && start) begin
         rd_seen_q <= '0;
         wr_seen_q <= '0;
      end else if (mem_req && mem_ack) begin
         if (mem_we) wr_seen_q <= wr_seen_q + CNT_W'(1);
         else        rd_seen_q <= rd_seen_q + CNT_W'(1);
      end
   end

   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R4
   AST_READS_PER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rd_seen_q == CNT_W'(LOAD_WORDS))); // R3
   AST_WRITES_PER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wr_seen_q == CNT_W'(2))); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(mem_req && mem_we && mem_ack) && !busy)); // R7
   AST_BASES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(key_q) && $stable(src_q) && $stable(dst_q))); // R2
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R8
endmodule

// File: tb/idea_seq_core_test.sv
`timescale 1ns/1ps
module idea_seq_core_test;
   localparam int AW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] key_base = '0, src_base = '0, dst_base = '0;
   logic busy, done, mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic ack_r = 1'b0;
   logic [31:0] rdata_r = '0;

   always #4 clk = ~clk;

   idea_seq_core #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .key_base(key_base), .src_base(src_base), .dst_base(dst_base),
      .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(ack_r), .mem_rdata(rdata_r)
   );

   int checks = 0;
   int errors = 0;
   logic [31:0] mem [256];
   logic [15:0] zk [52];

   // memory model state and access log
   int unsigned lat = 0, wcnt = 0;
   int acc_idx = 0, rd_n = 0, wr_n = 0, order_err = 0, hold_err = 0;
   int exp_key = 0, exp_src = 0, exp_dst = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ack_r <= 1'b0;
         wcnt = 0;
      end else if (ack_r) begin
         ack_r <= 1'b0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            int ea;
            wcnt = 0;
            ack_r <= 1'b1;
            if (acc_idx < 2)       ea = exp_src + acc_idx;
            else if (acc_idx < 28) ea = exp_key + acc_idx - 2;
            else                   ea = exp_dst + acc_idx - 28;
            if (int'(mem_addr) != ea || mem_we != (acc_idx >= 28)) order_err++;
            if (mem_we) begin
               mem[mem_addr[7:0]] = mem_wdata;
               wr_n++;
            end else begin
               rdata_r <= mem[mem_addr[7:0]];
               rd_n++;
            end
            acc_idx++;
         end else begin
            wcnt = wcnt + 1;
         end
      end
   end

   logic p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [31:0] p_wd = '0;
   always @(negedge clk) begin
      if (rst_n && p_req && !p_ack)
         if (!mem_req || mem_we != p_we || mem_addr != p_addr || mem_wdata != p_wd) hold_err++;
      p_req = mem_req; p_ack = ack_r; p_we = mem_we; p_addr = mem_addr; p_wd = mem_wdata;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mulm(input logic [15:0] a, input logic [15:0] b);
      longint unsigned aa, bb, r;
      aa = (a == 0) ? 65536 : a;
      bb = (b == 0) ? 65536 : b;
      r  = (aa * bb) % 65537;
      return r[15:0];
   endfunction

   function automatic logic [63:0] ref_encrypt(input logic [63:0] pt);
      logic [15:0] x1, x2, x3, x4, a, b, c, d, e, f, g;
      {x1, x2, x3, x4} = pt;
      for (int r = 0; r < 8; r++) begin
         a = mulm(x1, zk[6*r]);   b = x2 + zk[6*r+1];
         c = x3 + zk[6*r+2];      d = mulm(x4, zk[6*r+3]);
         e = mulm(a ^ c, zk[6*r+4]);
         f = mulm((b ^ d) + e, zk[6*r+5]);
         g = e + f;
         x1 = a ^ f; x2 = c ^ f; x3 = b ^ g; x4 = d ^ g;
      end
      return {mulm(x1, zk[48]), x3 + zk[49], x2 + zk[50], mulm(x4, zk[51])};
   endfunction

   task automatic expand_key(input logic [127:0] key);
      logic [127:0] k = key;
      for (int i = 0; i < 52; i++) begin
         zk[i] = k[127 - 16*(i%8) -: 16];
         if (i % 8 == 7) k = {k[102:0], k[127:103]};
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one block; returns ciphertext read back from memory
   task automatic run_block(input int kb, input int sb, input int db, input int unsigned l,
                            input logic [63:0] pt, input bit intrude, output logic [63:0] ct);
      int t;
      for (int j = 0; j < 26; j++) mem[kb + j] = {zk[2*j], zk[2*j+1]};
      mem[sb] = pt[63:32]; mem[sb + 1] = pt[31:0];
      mem[db] = '0; mem[db + 1] = '0;
      mem[200] = 32'hDEAD0000; mem[201] = 32'hDEAD0001;
      lat = l; exp_key = kb; exp_src = sb; exp_dst = db;
      acc_idx = 0; rd_n = 0; wr_n = 0; order_err = 0; hold_err = 0;
      key_base = AW'(kb); src_base = AW'(sb); dst_base = AW'(db);
      start = 1'b1; @(negedge clk); start = 1'b0;
      if (intrude) begin
         wait_cycles(5);
         key_base = AW'(150); src_base = AW'(180); dst_base = AW'(200);
         start = 1'b1; @(negedge clk); start = 1'b0;
      end
      t = 0;
      while (!done && t < 5000) begin @(negedge clk); t++; end
      check(t < 5000, "R7", "done reached", 64'(t), 64'd0);
      check(!busy, "R7", "busy low with done", 64'(busy), 64'd0);
      @(negedge clk);
      check(!done, "R7", "done lasts one cycle", 64'(done), 64'd0);
      check(rd_n == 28, "R3", "read count", 64'(rd_n), 64'd28);
      check(wr_n == 2, "R6", "write count", 64'(wr_n), 64'd2);
      check(order_err == 0, "R3", "command order and addresses", 64'(order_err), 64'd0);
      check(hold_err == 0, "R4", "command held until ack", 64'(hold_err), 64'd0);
      ct = {mem[db], mem[db + 1]};
      if (intrude) begin
         wait_cycles(10);
         check(!busy && !mem_req, "R2", "start while busy caused no rerun", 64'({busy, mem_req}), 64'd0);
         check({mem[200], mem[201]} == 64'hDEAD0000DEAD0001, "R2", "ignored destination untouched",
               {mem[200], mem[201]}, 64'hDEAD0000DEAD0001);
      end else begin
         wait_cycles(3);
         check(!mem_req, "R8", "no request while idle", 64'(mem_req), 64'd0);
      end
   endtask

   initial begin
      for (int i = 0; i < 400000; i++) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] ct, pt, expv;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) mem[i] = '0;
      wait_cycles(3);
      check(!busy && !done && !mem_req, "R1", "reset outputs", 64'({busy, done, mem_req}), 64'd0);
      rst_n = 1'b1;
      wait_cycles(2);
      check(!busy && !mem_req, "R1", "idle after reset", 64'({busy, mem_req}), 64'd0);

      // published vector
      expand_key(128'h0001_0002_0003_0004_0005_0006_0007_0008);
      run_block(0, 64, 96, 0, 64'h0000_0001_0002_0003, 1'b0, ct);
      check(ct == 64'h11FB_ED2B_0198_6DE5, "R5", "known vector", ct, 64'h11FBED2B01986DE5);
      check(ct == ref_encrypt(64'h0000_0001_0002_0003), "R6", "word placement", ct,
            ref_encrypt(64'h0000_0001_0002_0003));

      // all-zero subkeys: every multiply takes the 65536 path
      for (int i = 0; i < 52; i++) zk[i] = 16'd0;
      run_block(10, 70, 110, 2, 64'h0, 1'b0, ct);
      expv = ref_encrypt(64'h0);
      check(ct == expv, "R5", "zero subkeys zero block", ct, expv);

      // subkeys of 1 and 0xFFFF
      for (int i = 0; i < 52; i++) zk[i] = (i % 2 == 0) ? 16'd1 : 16'hFFFF;
      pt = 64'hFFFF_0000_FFFF_0000;
      run_block(30, 66, 120, 1, pt, 1'b0, ct);
      expv = ref_encrypt(pt);
      check(ct == expv, "R5", "extreme subkeys", ct, expv);

      // start while busy is ignored
      expand_key(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
      pt = 64'h0102_0304_0506_0708;
      run_block(5, 90, 130, 3, pt, 1'b1, ct);
      expv = ref_encrypt(pt);
      check(ct == expv, "R2", "result of original addresses", ct, expv);

      // random tables, blocks and latencies
      for (int n = 0; n < 8; n++) begin
         int kb, sb, db;
         for (int i = 0; i < 52; i++) zk[i] = 16'($urandom);
         if (n == 3) zk[5] = 16'd0;
         pt = {$urandom, $urandom};
         kb = int'($urandom % 30);
         sb = 64 + int'($urandom % 16);
         db = 100 + int'($urandom % 40);
         run_block(kb, sb, db, $urandom % 4, pt, 1'b0, ct);
         expv = ref_encrypt(pt);
         check(ct == expv, "R5", "random block", ct, expv);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule